// File: doc/BRIEF.md
# Daisy-Chained Bus Requester

This block is the per-master front end that lets one device compete for a shared bus. The bus has four prioritised request lines, where level 3 is the highest priority and level 0 the lowest. It also has one grant line per level, a bus-busy line and a bus-clear line. Each grant line runs from device to device as a daisy chain. The device nearest the central arbiter sees a grant first, so masters that share a level are ranked by their position on the chain.

The local side holds `want_bus_i` high while it needs the bus. The block then raises the request line of its build-time level and waits for a grant on that level. A grant that arrives while the request is pending is kept and not passed on. The block then drops its request, drives bus-busy and reports ownership through `owned_o`. An idle block forwards every grant down the chain without a register stage.

While the block owns the bus, dropping `want_bus_i` releases the bus. If bus-clear is raised at a level below 3, the block first lets the local side finish its transfer, which is signalled on `xfer_done_i`, and then releases bus-busy. A level-3 owner ignores bus-clear.

Top module: `bus_requester`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. In the cycle after a reset edge, `bus_req_o` is 0, `bus_busy_o` is 0 and `owned_o` is 0.
- R2: When idle with `want_bus_i` high at a clock edge, the block drives its request from the next cycle on. `bus_req_o` equals `1 << PRIO_LEVEL`, with bit i standing for request level i, and no other bit is ever set.
- R3: Bits of `grant_out_o` for levels other than `PRIO_LEVEL` always equal the matching bits of `grant_in_i` in the same cycle.
- R4: Bit `PRIO_LEVEL` of `grant_out_o` equals `grant_in_i[PRIO_LEVEL]` in the same cycle while the block is idle. It is 0 while the block is requesting, owning or draining.
- R5: A grant on its own level while the block is requesting is taken at that edge. In the next cycle `owned_o` and `bus_busy_o` are 1 and `bus_req_o` is 0. The grant is taken even if `want_bus_i` falls in the same cycle.
- R6: An owner with `want_bus_i` low at a clock edge releases the bus. In the next cycle `bus_busy_o` and `owned_o` are 0. This check comes before the bus-clear check.
- R7: For `PRIO_LEVEL` below 3, an owner that sees `bus_clear_i` enters a drain phase. It keeps `bus_busy_o` and `owned_o` high until an edge with `xfer_done_i` high or `want_bus_i` low, and releases in the cycle after that edge.
- R8: For `PRIO_LEVEL` equal to 3, `bus_clear_i` has no effect. The owner keeps `bus_busy_o` high for as long as `want_bus_i` stays high.
- R9: A request withdrawn before any grant, with `want_bus_i` low at an edge with no own-level grant, removes `bus_req_o` in the next cycle and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| want_bus_i | input | 1 | Local side needs the bus |
| xfer_done_i | input | 1 | Local side finished its current transfer |
| bus_clear_i | input | 1 | Bus-clear request from the arbiter |
| grant_in_i | input | 4 | Grant lines arriving from the upstream chain neighbour, bit i for level i |
| grant_out_o | output | 4 | Grant lines passed to the downstream neighbour |
| bus_req_o | output | 4 | Request lines, one-hot on the block's level |
| bus_busy_o | output | 1 | Bus-busy drive while owning |
| owned_o | output | 1 | Ownership flag to the local side |

## Verification
Every state result (`bus_req_o`, `bus_busy_o`, `owned_o`) is due one clock after the edge that samples the stimulus. `grant_out_o` is due in the same cycle as `grant_in_i`, with no register between them. The bench drives inputs just after a falling edge. It checks `grant_out_o` 1 ns later against the current state. After the next rising edge it advances its own model and, at the following falling edge, compares the registered outputs. A level-1 instance and a level-3 instance share the stimulus, so pre-emption and its absence are seen side by side.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;
  localparam int NUM_LEVELS = 4;
  localparam int LEVEL_W    = $clog2(NUM_LEVELS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_OWN   = 2'd2,
    ST_DRAIN = 2'd3
  } req_state_e;
endpackage

// File: rtl/req_ctrl_fsm.sv
module req_ctrl_fsm
  import bus_req_pkg::*;
#(
  parameter logic [LEVEL_W-1:0] PRIO_LEVEL = 1,
  parameter bit                 PREEMPTIBLE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  want_bus_i,
  input  logic                  xfer_done_i,
  input  logic                  bus_clear_i,
  input  logic                  own_grant_i,
  output logic [NUM_LEVELS-1:0] bus_req_o,
  output logic                  bus_busy_o,
  output logic                  owned_o,
  output logic                  idle_o
);
  localparam logic [NUM_LEVELS-1:0] REQ_MASK = NUM_LEVELS'(1) << PRIO_LEVEL;

  req_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (want_bus_i) state_d = ST_REQ;
      ST_REQ: begin
        if (own_grant_i)      state_d = ST_OWN;
        else if (!want_bus_i) state_d = ST_IDLE;
      end
      ST_OWN: begin
        if (!want_bus_i)                      state_d = ST_IDLE;
        else if (bus_clear_i && PREEMPTIBLE)  state_d = ST_DRAIN;
      end
      ST_DRAIN: if (xfer_done_i || !want_bus_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bus_req_o  <= '0;
      bus_busy_o <= 1'b0;
      owned_o    <= 1'b0;
      idle_o     <= 1'b1;
    end else begin
      state_q    <= state_d;
      bus_req_o  <= (state_d == ST_REQ) ? REQ_MASK : '0;
      bus_busy_o <= (state_d == ST_OWN) || (state_d == ST_DRAIN);
      owned_o    <= (state_d == ST_OWN) || (state_d == ST_DRAIN);
      idle_o     <= (state_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/grant_chain.sv
module grant_chain
  import bus_req_pkg::*;
#(
  parameter logic [LEVEL_W-1:0] PRIO_LEVEL = 1
) (
  input  logic [NUM_LEVELS-1:0] grant_in_i,
  input  logic                  pass_own_i,
  output logic [NUM_LEVELS-1:0] grant_out_o,
  output logic                  own_grant_o
);
  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
    if (lv == int'(PRIO_LEVEL)) begin : g_own
      assign grant_out_o[lv] = grant_in_i[lv] & pass_own_i;
    end else begin : g_thru
      assign grant_out_o[lv] = grant_in_i[lv];
    end
  end

  assign own_grant_o = grant_in_i[PRIO_LEVEL];
endmodule

// File: rtl/bus_requester.sv
module bus_requester
  import bus_req_pkg::*;
#(
  parameter logic [1:0] PRIO_LEVEL = 2'd1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       want_bus_i,
  input  logic       xfer_done_i,
  input  logic       bus_clear_i,
  input  logic [3:0] grant_in_i,
  output logic [3:0] grant_out_o,
  output logic [3:0] bus_req_o,
  output logic       bus_busy_o,
  output logic       owned_o
);
  localparam bit PREEMPT = (int'(PRIO_LEVEL) != NUM_LEVELS - 1);

  logic idle;
  logic own_grant;

  grant_chain #(.PRIO_LEVEL(PRIO_LEVEL)) u_chain (
    .grant_in_i  (grant_in_i),
    .pass_own_i  (idle),
    .grant_out_o (grant_out_o),
    .own_grant_o (own_grant)
  );

  req_ctrl_fsm #(.PRIO_LEVEL(PRIO_LEVEL), .PREEMPTIBLE(PREEMPT)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .want_bus_i  (want_bus_i),
    .xfer_done_i (xfer_done_i),
    .bus_clear_i (bus_clear_i),
    .own_grant_i (own_grant),
    .bus_req_o   (bus_req_o),
    .bus_busy_o  (bus_busy_o),
    .owned_o     (owned_o),
    .idle_o      (idle)
  );
endmodule

// File: rtl/bus_requester_chk.sv
module bus_requester_chk #(
  parameter logic [1:0] PRIO_LEVEL = 2'd1
) (
  input logic       clk,
  input logic       rst,
  input logic       want_bus_i,
  input logic       xfer_done_i,
  input logic       bus_clear_i,
  input logic [3:0] grant_in_i,
  input logic [3:0] grant_out_o,
  input logic [3:0] bus_req_o,
  input logic       bus_busy_o,
  input logic       owned_o
);
  localparam logic [3:0] LV_MASK = 4'b0001 << PRIO_LEVEL;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (bus_req_o == 4'b0 && !bus_busy_o && !owned_o));  // R1

  AST_REQ_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_req_o) && ((bus_req_o & ~LV_MASK) == 4'b0));  // R2

  AST_OTHER_LEVELS_THRU: assert property (@(posedge clk) disable iff (rst)
    (grant_out_o & ~LV_MASK) == (grant_in_i & ~LV_MASK));  // R3

  AST_OWN_GRANT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    ((bus_req_o != 4'b0) || owned_o) |-> ((grant_out_o & LV_MASK) == 4'b0));  // R4

  AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ((bus_req_o & LV_MASK & grant_in_i) != 4'b0) |=> (owned_o && bus_busy_o && bus_req_o == 4'b0));  // R5

  AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    (owned_o && !want_bus_i) |=> (!owned_o && !bus_busy_o));  // R6

  if (PRIO_LEVEL != 2'd3) begin : g_low
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      (owned_o && want_bus_i && !xfer_done_i) |=> bus_busy_o);  // R7
  end else begin : g_top
    AST_TOP_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
      (owned_o && want_bus_i) |=> (owned_o && bus_busy_o));  // R8
  end
endmodule

bind bus_requester bus_requester_chk #(.PRIO_LEVEL(PRIO_LEVEL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .want_bus_i  (want_bus_i),
  .xfer_done_i (xfer_done_i),
  .bus_clear_i (bus_clear_i),
  .grant_in_i  (grant_in_i),
  .grant_out_o (grant_out_o),
  .bus_req_o   (bus_req_o),
  .bus_busy_o  (bus_busy_o),
  .owned_o     (owned_o)
);

// File: tb/sim_bus_requester.sv
`timescale 1ns/1ps
module sim_bus_requester;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       want = 1'b0, done = 1'b0, bclr = 1'b0;
  logic [3:0] gin = 4'b0;
  logic [3:0] gout0, req0, gout1, req1;
  logic       busy0, own0, busy1, own1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int st0 = 0, st1 = 0;  // 0 idle, 1 requesting, 2 owning, 3 draining

  always #2.5 clk = ~clk;

  bus_requester #(.PRIO_LEVEL(2'd1)) u0 (
    .clk(clk), .rst(rst), .want_bus_i(want), .xfer_done_i(done), .bus_clear_i(bclr),
    .grant_in_i(gin), .grant_out_o(gout0), .bus_req_o(req0), .bus_busy_o(busy0), .owned_o(own0));

  bus_requester #(.PRIO_LEVEL(2'd3)) u1 (
    .clk(clk), .rst(rst), .want_bus_i(want), .xfer_done_i(done), .bus_clear_i(bclr),
    .grant_in_i(gin), .grant_out_o(gout1), .bus_req_o(req1), .bus_busy_o(busy1), .owned_o(own1));

  function automatic int next_st(int st, int lev, logic w, logic d, logic c, logic [3:0] g);
    case (st)
      0: return w ? 1 : 0;
      1: return g[lev] ? 2 : (w ? 1 : 0);
      2: return !w ? 0 : ((c && lev != 3) ? 3 : 2);
      default: return (d || !w) ? 0 : 3;
    endcase
  endfunction

  function automatic logic [3:0] exp_req(int st, int lev);
    return (st == 1) ? (4'b0001 << lev) : 4'b0000;
  endfunction

  function automatic logic [3:0] exp_gout(int st, int lev, logic [3:0] g);
    return (st == 0) ? g : (g & ~(4'b0001 << lev));
  endfunction

  task automatic cmp(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_grants(string tag);
    cmp(tag, "u0 grant_out", gout0, exp_gout(st0, 1, gin));
    cmp(tag, "u1 grant_out", gout1, exp_gout(st1, 3, gin));
  endtask

  task automatic check_state(string tag);
    cmp(tag, "u0 bus_req", req0, exp_req(st0, 1));
    cmp(tag, "u0 busy", {3'b0, busy0}, {3'b0, st0 >= 2});
    cmp(tag, "u0 owned", {3'b0, own0}, {3'b0, st0 >= 2});
    cmp(tag, "u1 bus_req", req1, exp_req(st1, 3));
    cmp(tag, "u1 busy", {3'b0, busy1}, {3'b0, st1 >= 2});
    cmp(tag, "u1 owned", {3'b0, own1}, {3'b0, st1 >= 2});
  endtask

  // Inputs already applied after a falling edge; check forwarding, clock, check state.
  task automatic step(string tag);
    #1 check_grants(tag);
    @(posedge clk);
    if (rst) begin st0 = 0; st1 = 0; end
    else begin
      st0 = next_st(st0, 1, want, done, bclr, gin);
      st1 = next_st(st1, 3, want, done, bclr, gin);
    end
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic apply(logic w, logic d, logic c, logic [3:0] g);
    want = w; done = d; bclr = c; gin = g;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);
    apply(1, 0, 0, 4'b0000);
    step("R1 reset");
    step("R1 reset");
    rst = 1'b0;
    apply(0, 0, 0, 4'b1111);
    step("R4 idle forward R3");
    apply(1, 0, 0, 4'b0000);
    step("R2 request raised");
    apply(1, 0, 0, 4'b0010);
    step("R5 u0 takes grant R4 blocked");
    apply(1, 0, 0, 4'b1000);
    step("R5 u1 takes grant");
    apply(1, 0, 1, 4'b1111);
    step("R7 drain entered R8 top ignores clear");
    apply(1, 0, 0, 4'b1111);
    step("R7 drain holds busy");
    apply(1, 1, 0, 4'b0000);
    step("R7 release after done");
    apply(0, 0, 0, 4'b0000);
    step("R6 voluntary release R9 withdraw");
    apply(1, 0, 0, 4'b0000);
    step("R2 request again");
    apply(0, 0, 0, 4'b0000);
    step("R9 withdraw before grant");
    rst = 1'b1;
    apply(1, 0, 0, 4'b0000);
    step("R1 reset mid-run");
    rst = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 8) != 0, ($urandom % 4) == 0, ($urandom % 6) == 0,
            4'($urandom) & 4'($urandom));
      step("R3 R4 R5 R6 R7 R8 random");
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule